// File: doc/BRIEF.md
# Triggered One-Shot Pulse Timer

This block is a single timer channel that issues one delayed pulse per trigger. While it is disabled, or while it is enabled but waiting, its up-counter rests at all-ones. A trigger moves the counter to zero and starts counting. The counter advances once on each clock where the prescaler's count enable is high. Each of the delay channels drives its pulse output active once the count reaches that channel's delay value. All channels share one period value that ends the pulse. When the period value has been counted through, the counter returns to all-ones and waits for the next trigger.

A trigger comes from one of two places. Software can raise a one-cycle strobe. The external trigger input can also start a pulse on a selectable edge. A trigger that arrives while a pulse is running is dropped. An interrupt strobe is raised when the counter reaches the period value. Each delay channel raises its own strobe when the counter reaches its delay value. Each pulse output has a polarity bit. The prescaler and the register bus are outside this block, which sees its settings as plain inputs.

Top module: `oneshot_timer`

## Requirements
- R1: With the enable high and the mode field at 3'b011, the counter stays at 16'hFFFF until a trigger. Neither enabling nor leaving the block idle starts a count.
- R2: A software trigger strobe starts the count. At the first clock edge where the strobe is seen, `count_o` becomes 0. After that it rises by one at each clock edge where `cnt_tick_i` is high.
- R3: `edge_sel_i` selects which change on `ext_trig_i` is a trigger: 2'b00 none, 2'b01 rising, 2'b10 falling, 2'b11 both. No external edge is a trigger while the block is disarmed.
- R4: Delay channel k is active while a count runs and `count_o` is at least that channel's delay value. A channel whose delay is above the period value never becomes active.
- R5: A pulse lasts for (period − delay + 1) count ticks. The tick that follows the count equal to the period value loads 16'hFFFF and stops the counter.
- R6: A trigger seen while a count runs is discarded. This includes a trigger in the same cycle as the tick that ends the pulse: the counter still goes to 16'hFFFF and stays there.
- R7: `irq_period_o` is high for exactly one clock, in the cycle where `count_o` first shows the period value during a run. `irq_delay_o[k]` does the same for delay channel k's value. A delay of 0 fires together with the start.
- R8: `pulse_o[k]` equals the channel's active state XOR `out_pol_i[k]`. A polarity of 1 gives an active-low output. When idle, each pin rests at its polarity bit.
- R9: If the enable goes low, or the mode field is anything other than 3'b011, the block is disarmed. At the next clock edge the counter is at 16'hFFFF and no run is in progress, so every pin returns to its idle level and triggers are not accepted.
- R10: While `cnt_tick_i` is low, a running count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| cnt_tick_i | input | 1 | Count enable from the prescaler |
| enable_i | input | 1 | Counter enable |
| mode_i | input | 3 | Mode field; 3'b011 selects one-shot |
| sw_trig_i | input | 1 | Software trigger strobe |
| ext_trig_i | input | 1 | External trigger level |
| edge_sel_i | input | 2 | External trigger edge select |
| period_cmp_i | input | 16 | Period compare value |
| delay_cmp_i | input | NCH x 16 | Delay compare value per channel |
| out_pol_i | input | NCH | Output polarity per channel (1 = active-low) |
| count_o | output | 16 | Current counter value |
| pulse_o | output | NCH | Pulse outputs |
| irq_period_o | output | 1 | Period match strobe |
| irq_delay_o | output | NCH | Delay match strobes |

## Verification
Two events can fall in the same clock: a trigger, and the tick that ends a pulse. To provoke this, every table vector raises the software strobe in the cycle where `count_o` equals the period value. It also raises it once mid-pulse. The bench then requires the counter to be 16'hFFFF on the following cycle and to remain there. The same pairing also shows up in two other forms. With a period of 0, the start cycle and the end cycle are the same cycle, and the period and delay strobes must fire together. Separately, a disarm arrives in the middle of a pulse, and the bench checks that the pins return to their polarity levels at the next edge.

// File: rtl/ost_pkg.sv
package ost_pkg;
    localparam int CNT_W = 16;
    localparam logic [2:0] MODE_ONESHOT = 3'b011;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } cnt_state_t;
endpackage

// File: rtl/ost_trig.sv
module ost_trig
    import ost_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       arm_i,
    input  logic       sw_i,
    input  logic       ext_i,
    input  logic [1:0] sel_i,
    output logic       trig_o
);
    logic ext_d, ext_q;
    logic rise, fall, hit;

    always_comb begin
        ext_d = ext_i;
        rise  = ext_i & ~ext_q;
        fall  = ~ext_i & ext_q;
        case (edge_sel_e'(sel_i))
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        trig_o = arm_i & (sw_i | hit);
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) ext_q <= 1'b0;
        else          ext_q <= ext_d;
    end

    // R3: a disarmed block never reports a trigger
    a_r3_disarmed_quiet: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !arm_i |-> !trig_o);
endmodule

// File: rtl/ost_cnt.sv
module ost_cnt
    import ost_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             arm_i,
    input  logic             tick_i,
    input  logic             trig_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             active_o,
    output logic             irq_o,
    output logic [CNT_W-1:0] nxt_cnt_o,
    output logic             nxt_active_o,
    output logic             step_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_state_t st_d, st_q;
    logic       step;

    always_comb begin
        st_d = st_q;
        step = 1'b0;
        if (!arm_i) begin
            st_d.active = 1'b0;
            st_d.cnt    = '1;
        end else if (!st_q.active) begin
            if (trig_i) begin
                st_d.active = 1'b1;
                st_d.cnt    = '0;
                step        = 1'b1;
            end
        end else if (tick_i) begin
            step = 1'b1;
            if (st_q.cnt >= period_i) begin
                st_d.active = 1'b0;
                st_d.cnt    = '1;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end
        st_d.irq = step & st_d.active & (st_d.cnt == period_i);
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) st_q <= '{active: 1'b0, cnt: '1, irq: 1'b0};
        else          st_q <= st_d;
    end

    assign cnt_o        = st_q.cnt;
    assign active_o     = st_q.active;
    assign irq_o        = st_q.irq;
    assign nxt_cnt_o    = st_d.cnt;
    assign nxt_active_o = st_d.active;
    assign step_o       = step;

    // R1: an idle counter is parked at all-ones
    a_r1_idle_parked: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !st_q.active |-> (st_q.cnt == '1));
    // R2: every run begins at zero
    a_r2_start_zero: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(st_q.active) |-> (st_q.cnt == '0));
    // R10: no tick, no movement
    a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (st_q.active && arm_i && !tick_i) |=> $stable(st_q.cnt));
    // R9: disarm parks the counter at the next edge
    a_r9_disarm_parks: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !arm_i |=> (!st_q.active && st_q.cnt == '1));
    // R7: period strobe lasts one cycle
    a_r7_period_single: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        st_q.irq |=> !st_q.irq);
endmodule

// File: rtl/ost_chan.sv
module ost_chan
    import ost_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             active_i,
    input  logic [CNT_W-1:0] nxt_cnt_i,
    input  logic             nxt_active_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] dly_i,
    input  logic             pol_i,
    output logic             pulse_o,
    output logic             irq_o
);
    logic irq_d, irq_q;
    logic on;

    always_comb begin
        on      = active_i & (cnt_i >= dly_i);
        pulse_o = on ^ pol_i;
        irq_d   = step_i & nxt_active_i & (nxt_cnt_i == dly_i);
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) irq_q <= 1'b0;
        else          irq_q <= irq_d;
    end

    assign irq_o = irq_q;

    // R8: idle pin rests at its polarity level
    a_r8_idle_level: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !active_i |-> (pulse_o == pol_i));
    // R4: no activity before the delay is reached
    a_r4_before_delay: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (active_i && cnt_i < dly_i) |-> (pulse_o == pol_i));
    // R7: delay strobe lasts one cycle
    a_r7_delay_single: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        irq_q |=> !irq_q);
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
    import ost_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                      clk_i,
    input  logic                      rst_n_i,
    input  logic                      cnt_tick_i,
    input  logic                      enable_i,
    input  logic [2:0]                mode_i,
    input  logic                      sw_trig_i,
    input  logic                      ext_trig_i,
    input  logic [1:0]                edge_sel_i,
    input  logic [CNT_W-1:0]          period_cmp_i,
    input  logic [NCH-1:0][CNT_W-1:0] delay_cmp_i,
    input  logic [NCH-1:0]            out_pol_i,
    output logic [CNT_W-1:0]          count_o,
    output logic [NCH-1:0]            pulse_o,
    output logic                      irq_period_o,
    output logic [NCH-1:0]            irq_delay_o
);
    logic             arm;
    logic             trig;
    logic             active;
    logic [CNT_W-1:0] nxt_cnt;
    logic             nxt_active;
    logic             step;

    assign arm = enable_i & (mode_i == MODE_ONESHOT);

    ost_trig u_trig (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .arm_i   (arm),
        .sw_i    (sw_trig_i),
        .ext_i   (ext_trig_i),
        .sel_i   (edge_sel_i),
        .trig_o  (trig)
    );

    ost_cnt u_cnt (
        .clk_i        (clk_i),
        .rst_n_i      (rst_n_i),
        .arm_i        (arm),
        .tick_i       (cnt_tick_i),
        .trig_i       (trig),
        .period_i     (period_cmp_i),
        .cnt_o        (count_o),
        .active_o     (active),
        .irq_o        (irq_period_o),
        .nxt_cnt_o    (nxt_cnt),
        .nxt_active_o (nxt_active),
        .step_o       (step)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        ost_chan u_chan (
            .clk_i        (clk_i),
            .rst_n_i      (rst_n_i),
            .cnt_i        (count_o),
            .active_i     (active),
            .nxt_cnt_i    (nxt_cnt),
            .nxt_active_i (nxt_active),
            .step_i       (step),
            .dly_i        (delay_cmp_i[k]),
            .pol_i        (out_pol_i[k]),
            .pulse_o      (pulse_o[k]),
            .irq_o        (irq_delay_o[k])
        );
    end

    // R6: a running pulse is never restarted at zero by a trigger
    a_r6_no_restart: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (active && count_o != '0) |=> (count_o != '0));
endmodule

// File: tb/sim_oneshot_timer.sv
module sim_oneshot_timer;
    typedef struct packed {
        logic [15:0] per;
        logic [15:0] d0;
        logic [15:0] d1;
        logic [15:0] d2;
        logic [2:0]  pol;
        logic [1:0]  how;   // 0 software, 1 rise, 2 fall, 3 both
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{16'd5,  16'd1, 16'd3, 16'd5,  3'b000, 2'd0},
        '{16'd7,  16'd0, 16'd7, 16'd9,  3'b101, 2'd1},
        '{16'd0,  16'd0, 16'd0, 16'd0,  3'b010, 2'd2},
        '{16'd10, 16'd4, 16'd2, 16'd11, 3'b111, 2'd3},
        '{16'd3,  16'd3, 16'd1, 16'd2,  3'b000, 2'd0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b1;
    logic             en = 1'b0;
    logic [2:0]       mode = 3'b011;
    logic             sw = 1'b0;
    logic             ext = 1'b0;
    logic [1:0]       sel = 2'b00;
    logic [15:0]      per = '0;
    logic [2:0][15:0] dly = '0;
    logic [2:0]       pol = '0;
    logic [15:0]      count;
    logic [2:0]       pulse;
    logic             irq_p;
    logic [2:0]       irq_d;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    oneshot_timer #(.NCH(3)) u0 (
        .clk_i(clk), .rst_n_i(rst_n), .cnt_tick_i(tick), .enable_i(en),
        .mode_i(mode), .sw_trig_i(sw), .ext_trig_i(ext), .edge_sel_i(sel),
        .period_cmp_i(per), .delay_cmp_i(dly), .out_pol_i(pol),
        .count_o(count), .pulse_o(pulse), .irq_period_o(irq_p),
        .irq_delay_o(irq_d)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 60000) begin
            mismatched++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic run_vec(input vec_t v);
        int p;
        logic [2:0] ep, ei;
        p = int'(v.per);
        per = v.per; dly[0] = v.d0; dly[1] = v.d1; dly[2] = v.d2; pol = v.pol;
        en = 1'b1; mode = 3'b011;
        if (v.how == 2'd0) begin
            sw = 1'b1;
            @(negedge clk);
            sw = 1'b0;
        end else begin
            sel = 2'b00;
            ext = (v.how == 2'd2);
            repeat (2) @(negedge clk);
            sel = v.how;
            ext = ~ext;
            @(negedge clk);
        end
        for (int n = 0; n <= p + 1; n++) begin
            logic run;
            run = (n <= p);
            for (int k = 0; k < 3; k++) begin
                ep[k] = (run && n >= int'(dly[k])) ^ pol[k];
                ei[k] = run && n == int'(dly[k]);
            end
            chk("R2 R5 count", 32'(count), run ? 32'(n) : 32'hFFFF);
            chk("R4 R5 R8 pulse", 32'(pulse), 32'(ep));
            chk("R7 delay irq", 32'(irq_d), 32'(ei));
            chk("R7 period irq", 32'(irq_p), 32'(run && n == p));
            sw = ((n == 1) && (n <= p)) || (n == p);
            @(negedge clk);
            sw = 1'b0;
        end
        chk("R6 retrigger at end ignored", 32'(count), 32'hFFFF);
        @(negedge clk);
        chk("R6 stays parked", 32'(count), 32'hFFFF);
        sel = 2'b00; ext = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset count", 32'(count), 32'hFFFF);
        chk("R8 reset pulse", 32'(pulse), 32'h0);
        chk("R7 reset irq", 32'({irq_p, irq_d}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: enabling alone leaves the counter parked
        en = 1'b1; per = 16'd4;
        repeat (4) @(negedge clk);
        chk("R1 enable waits", 32'(count), 32'hFFFF);

        // Table walk
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R9: wrong mode refuses triggers
        mode = 3'b010; sw = 1'b1;
        @(negedge clk); sw = 1'b0;
        @(negedge clk);
        chk("R9 wrong mode no start", 32'(count), 32'hFFFF);
        mode = 3'b011;

        // R3: edges ignored while disabled
        en = 1'b0; sel = 2'b11; ext = 1'b1;
        @(negedge clk); ext = 1'b0;
        @(negedge clk);
        chk("R3 disabled edge ignored", 32'(count), 32'hFFFF);

        // R3: select none ignores edges
        en = 1'b1; sel = 2'b00; ext = 1'b1;
        @(negedge clk); ext = 1'b0;
        @(negedge clk);
        chk("R3 select none ignored", 32'(count), 32'hFFFF);

        // R3: falling select ignores rising edge
        sel = 2'b10; ext = 1'b1;
        @(negedge clk);
        chk("R3 rise under fall select", 32'(count), 32'hFFFF);
        sel = 2'b00; ext = 1'b0;
        @(negedge clk);

        // R9: disable mid pulse
        per = 16'd20; dly[0] = 16'd2; dly[1] = 16'd2; dly[2] = 16'd30; pol = 3'b001;
        sw = 1'b1;
        @(negedge clk); sw = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 mid pulse count", 32'(count), 32'd4);
        chk("R8 active-low active", 32'(pulse), 32'b010);
        en = 1'b0;
        @(negedge clk);
        chk("R9 disable parks", 32'(count), 32'hFFFF);
        chk("R9 pins idle", 32'(pulse), 32'b001);
        en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 re-enable waits", 32'(count), 32'hFFFF);

        // R10: count enable gaps
        tick = 1'b0; sw = 1'b1;
        @(negedge clk); sw = 1'b0;
        chk("R10 start without tick", 32'(count), 32'd0);
        repeat (3) @(negedge clk);
        chk("R10 held", 32'(count), 32'd0);
        tick = 1'b1;
        @(negedge clk);
        chk("R10 resumes", 32'(count), 32'd1);
        tick = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 held again", 32'(count), 32'd1);
        tick = 1'b1;
        en = 1'b0;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule